// File: doc/BRIEF.md
# Two-Wire Register-Access Slave

This block is a slave on a two-wire serial bus, with a clock line and an open-drain data line. It gives a bus master access to a small bank of 8-bit control registers. Both bus lines are sampled into the system clock domain. The block recognises start, repeated start and stop conditions. It compares the 7-bit device address in the first byte with its own address and loads the next byte of a write as the register pointer. After that it either stores data bytes or returns register contents. The pointer steps forward after every transferred byte, so one transaction can cover a run of adjacent registers.

A register read is done in three steps: a write that carries only the pointer, then a repeated start, then the address again with the direction bit set. The block returns one byte after another for as long as the master acknowledges each one. The low entries of the bank are fixed identification values. The block refuses any byte that would overwrite one of them by withholding the acknowledge, and it then leaves the bus alone until the next start or stop. The block only ever pulls the data line low: it has one drive-low output and never drives the line high.

Top module: `i2c_reg_slave`

## Requirements
- R1: After reset `sda_drive_o` is 0. The register defaults are: entry 0x0 = 0x05, entries 0x1, 0x2 and 0x3 = 0x51, 0x52 and 0x53, and entries 0x4 to 0xF = 0x00.
- R2: The first byte after a start holds the 7-bit address, most significant bit first, followed by a direction bit (0 = write, 1 = read). When the address equals `DEV_ADDR` (default 0x2A), the block pulls SDA low during the ninth clock as its acknowledge.
- R3: When the address does not match, the block gives no acknowledge and drives nothing until the next start. Registers are left unchanged.
- R4: In a write, the byte after the address is acknowledged and its low 4 bits become the register pointer.
- R5: In a write, each later data byte aimed at a writable entry is stored at the pointer and acknowledged. The pointer then increments and wraps from 0xF to 0x0.
- R6: A data byte aimed at a read-only entry (0x0 to 0x3) is neither acknowledged nor stored. The block then ignores the bus, so later bytes in the same transaction are not acknowledged either.
- R7: After a repeated start with the direction bit set to 1, the block acknowledges its address and then sends the register at the pointer, most significant bit first.
- R8: When the master acknowledges a read byte, the block sends the next register (pointer + 1, wrapping from 0xF to 0x0).
- R9: When the master does not acknowledge a read byte, the block releases SDA and drives nothing until the next start.
- R10: `sda_drive_o` changes only while SCL is low.
- R11: A stop condition in the middle of a data byte abandons that byte, and nothing is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as sampled |
| sda_i | input | 1 | Bus data line as sampled |
| sda_drive_o | output | 1 | 1 pulls the data line low |

## Verification
Four properties are checked on every cycle. The data drive changes only while the synchronised clock is low. Nothing is driven in the idle or ignore states. No write strobe reaches a read-only entry. Each accepted write advances the pointer by exactly one. Whether the correct bytes land in the correct registers can only be shown by the bench's scenarios. The same holds for wrap-around of streamed reads and writes, for the refusal after a write to a read-only entry, and for a mismatched address or an abandoned byte leaving the bank untouched. The bench confirms each of these by reading the bank back over the bus.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_MACK,
    ST_RLOAD,
    ST_IGNORE
  } slv_state_e;

  // Fixed identification contents of the read-only entries
  function automatic logic [7:0] id_value(input int unsigned idx);
    if (idx == 0) return 8'h05;
    return 8'(32'h50 + idx);
  endfunction

endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
      end
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_pipe[SYNC_STAGES-1];
      sda_q <= sda_pipe[SYNC_STAGES-1];
    end
  end

  assign scl_o      = scl_pipe[SYNC_STAGES-1];
  assign sda_o      = sda_pipe[SYNC_STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  // SDA edge while SCL held high across both samples
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;

  a_r11_start_stop_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_o, stop_o, scl_rise_o, scl_fall_o}));

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned RO_COUNT = 4,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       rdata_o,
  output logic             ro_o
);

  logic [7:0] mem [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (i < RO_COUNT) begin : g_ro
      assign mem[i] = i2c_slv_pkg::id_value(i);
    end else begin : g_rw
      logic [7:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                              q <= 8'h00;
        else if (we_i && idx_i == IDX_W'(i))      q <= wdata_i;
      end
      assign mem[i] = q;
    end
  end

  assign rdata_o = mem[idx_i];
  assign ro_o    = int'(idx_i) < RO_COUNT;

  a_r6_no_ro_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> !ro_o);

endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import i2c_slv_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'h2A,
  parameter int unsigned IDX_W    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_s_i,
  input  logic             sda_s_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [7:0]       rdata_i,
  input  logic             ro_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             we_o,
  output logic [7:0]       wdata_o,
  output logic             sda_drive_o
);

  slv_state_e       state_q, next_q;
  logic [IDX_W-1:0] ptr_q;
  logic [3:0]       cnt_q;
  logic [7:0]       shift_q, tx_q;
  logic             drive_q, ack_on_q;
  logic             byte_done;
  logic [7:0]       rx_byte;

  assign rx_byte   = {shift_q[6:0], sda_s_i};
  assign byte_done = scl_rise_i && cnt_q == 4'd7;
  assign we_o      = state_q == ST_WDATA && byte_done && !ro_i;
  assign wdata_o   = rx_byte;
  assign idx_o     = ptr_q;
  assign sda_drive_o = drive_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      next_q   <= ST_IDLE;
      ptr_q    <= '0;
      cnt_q    <= '0;
      shift_q  <= '0;
      tx_q     <= '0;
      drive_q  <= 1'b0;
      ack_on_q <= 1'b0;
    end else if (start_i) begin
      state_q  <= ST_ADDR;
      cnt_q    <= '0;
      drive_q  <= 1'b0;
      ack_on_q <= 1'b0;
    end else if (stop_i) begin
      state_q  <= ST_IDLE;
      drive_q  <= 1'b0;
      ack_on_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_PTR, ST_WDATA: begin
          if (scl_rise_i) begin
            shift_q <= rx_byte;
            cnt_q   <= cnt_q + 4'd1;
          end
          if (byte_done) begin
            if (state_q == ST_ADDR) begin
              if (rx_byte[7:1] == DEV_ADDR) begin
                state_q <= ST_ACK;
                next_q  <= rx_byte[0] ? ST_RDATA : ST_PTR;
              end else begin
                state_q <= ST_IGNORE;
              end
            end else if (state_q == ST_PTR) begin
              ptr_q   <= rx_byte[IDX_W-1:0];
              state_q <= ST_ACK;
              next_q  <= ST_WDATA;
            end else if (ro_i) begin
              state_q <= ST_IGNORE;
            end else begin
              ptr_q   <= ptr_q + 1'b1;
              state_q <= ST_ACK;
              next_q  <= ST_WDATA;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall_i) begin
            if (!ack_on_q) begin
              ack_on_q <= 1'b1;
              drive_q  <= 1'b1;
            end else begin
              ack_on_q <= 1'b0;
              cnt_q    <= '0;
              if (next_q == ST_RDATA) begin
                tx_q    <= rdata_i;
                drive_q <= ~rdata_i[7];
                state_q <= ST_RDATA;
              end else begin
                drive_q <= 1'b0;
                state_q <= next_q;
              end
            end
          end
        end
        ST_RDATA: begin
          if (scl_rise_i) cnt_q <= cnt_q + 4'd1;
          if (scl_fall_i) begin
            if (cnt_q == 4'd8) begin
              drive_q <= 1'b0;
              state_q <= ST_MACK;
            end else begin
              drive_q <= ~tx_q[3'(4'd7 - cnt_q)];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise_i) begin
            if (!sda_s_i) begin
              ptr_q   <= ptr_q + 1'b1;
              state_q <= ST_RLOAD;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_RLOAD: begin
          if (scl_fall_i) begin
            tx_q    <= rdata_i;
            drive_q <= ~rdata_i[7];
            cnt_q   <= '0;
            state_q <= ST_RDATA;
          end
        end
        default: ;
      endcase
    end
  end

  a_r10_drive_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($changed(drive_q) && !$past(start_i) && !$past(stop_i)) |-> !$past(scl_s_i));

  a_r9_idle_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !drive_q);

  a_r3_ignore_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IGNORE) |-> !drive_q);

  a_r5_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> ptr_q == $past(ptr_q) + 1'b1);

endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave #(
  parameter logic [6:0]  DEV_ADDR    = 7'h2A,
  parameter int unsigned NUM_REGS    = 16,
  parameter int unsigned RO_COUNT    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_drive_o
);

  localparam int unsigned IDX_W = $clog2(NUM_REGS);

  logic scl_s, sda_s, scl_rise, scl_fall, start, stop;
  logic we, ro;
  logic [IDX_W-1:0] idx;
  logic [7:0] wdata, rdata;

  i2c_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start),
    .stop_o     (stop)
  );

  i2c_slave_fsm #(.DEV_ADDR(DEV_ADDR), .IDX_W(IDX_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .scl_s_i     (scl_s),
    .sda_s_i     (sda_s),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .start_i     (start),
    .stop_i      (stop),
    .rdata_i     (rdata),
    .ro_i        (ro),
    .idx_o       (idx),
    .we_o        (we),
    .wdata_o     (wdata),
    .sda_drive_o (sda_drive_o)
  );

  i2c_reg_bank #(.NUM_REGS(NUM_REGS), .RO_COUNT(RO_COUNT)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .idx_i   (idx),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .ro_o    (ro)
  );

endmodule

// File: tb/i2c_reg_slave_tb_top.sv
module i2c_reg_slave_tb_top;

  localparam logic [6:0] ADDR = 7'h2A;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_drive;
  logic sda_line;

  always #2 clk = ~clk;

  assign sda_line = sda_m & ~sda_drive;

  i2c_reg_slave dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .scl_i       (scl_m),
    .sda_i       (sda_line),
    .sda_drive_o (sda_drive)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] model [16];
  logic drv_prev = 1'b0;
  int r10_viol = 0;

  always @(negedge clk) begin
    if (rst_ni && sda_drive != drv_prev && scl_m) r10_viol++;
    drv_prev = sda_drive;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; clks(8);
    scl_m = 1'b1; clks(8);
    sda_m = 1'b0; clks(8);
    scl_m = 1'b0; clks(4);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; clks(8);
    scl_m = 1'b1; clks(8);
    sda_m = 1'b1; clks(8);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; clks(8);
    scl_m = 1'b1; clks(8);
    scl_m = 1'b0; clks(2);
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; clks(8);
    scl_m = 1'b1; clks(4);
    b = sda_line; clks(4);
    scl_m = 1'b0; clks(2);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic nb;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(nb);
    ack = !nb;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic mack);
    for (int i = 7; i >= 0; i--) recv_bit(d[i]);
    send_bit(!mack);
  endtask

  // Burst read of n entries from pointer p, compared with the model
  task automatic do_read(input int p, input int n, input string req);
    logic ack;
    logic [7:0] d;
    bus_start();
    send_byte({ADDR, 1'b0}, ack); chk("R2", ack, 1);
    send_byte(8'(p), ack);        chk("R4", ack, 1);
    bus_start();
    send_byte({ADDR, 1'b1}, ack); chk("R7", ack, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(d, k != n - 1);
      chk(req, d, model[(p + k) % 16]);
    end
    bus_stop();
  endtask

  // Burst write of n bytes from pointer p
  task automatic do_write(input int p, input int n, input int seed);
    logic ack;
    bit refused = 0;
    bus_start();
    send_byte({ADDR, 1'b0}, ack); chk("R2", ack, 1);
    send_byte(8'(p), ack);        chk("R4", ack, 1);
    for (int k = 0; k < n; k++) begin
      int idx = (p + k) % 16;
      logic [7:0] v = 8'(seed * 29 + k * 53 + 7);
      send_byte(v, ack);
      if (refused || idx < 4) begin
        refused = 1;
        chk("R6", ack, 0);
      end else begin
        chk("R5", ack, 1);
        model[idx] = v;
      end
    end
    bus_stop();
  endtask

  initial begin
    logic ack, b;
    logic [7:0] d;
    model[0] = 8'h05; model[1] = 8'h51; model[2] = 8'h52; model[3] = 8'h53;
    for (int i = 4; i < 16; i++) model[i] = 8'h00;

    clks(5);
    chk("R1", sda_drive, 0);
    rst_ni = 1'b1;
    clks(5);
    chk("R1", sda_drive, 0);

    // R1 defaults, R8 streaming across the whole bank
    do_read(0, 16, "R1");

    // R5 single-byte writes to every writable entry
    for (int p = 4; p < 16; p++) do_write(p, 1, p);
    do_read(0, 16, "R8");
    // R8 wrap 0xF -> 0x0 while streaming
    do_read(12, 8, "R8");

    // R5 burst with increment, R5/R6 wrap into read-only entry 0
    do_write(8, 5, 100);
    do_write(13, 5, 200);
    do_read(0, 16, "R6");

    // R6 direct write to read-only entry 2
    do_write(2, 2, 300);
    do_read(2, 1, "R6");

    // R3 wrong address: no ack, later bytes ignored, bank untouched
    bus_start();
    send_byte({7'h2B, 1'b0}, ack); chk("R3", ack, 0);
    send_byte(8'h05, ack);         chk("R3", ack, 0);
    send_byte(8'hEE, ack);         chk("R3", ack, 0);
    bus_stop();
    bus_start();
    send_byte({7'h6A, 1'b1}, ack); chk("R3", ack, 0);
    recv_byte(d, 1'b1);            chk("R3", d, 8'hFF);
    bus_stop();
    do_read(5, 1, "R3");

    // R9 master NACK ends the read: line stays released
    bus_start();
    send_byte({ADDR, 1'b0}, ack); chk("R2", ack, 1);
    send_byte(8'h04, ack);        chk("R4", ack, 1);
    bus_start();
    send_byte({ADDR, 1'b1}, ack); chk("R7", ack, 1);
    recv_byte(d, 1'b0);           chk("R7", d, model[4]);
    for (int i = 0; i < 9; i++) begin
      recv_bit(b);
      chk("R9", b, 1);
    end
    chk("R9", sda_drive, 0);
    bus_stop();

    // R11 stop in the middle of a data byte
    bus_start();
    send_byte({ADDR, 1'b0}, ack); chk("R2", ack, 1);
    send_byte(8'h06, ack);        chk("R4", ack, 1);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_stop();
    do_read(6, 1, "R11");

    chk("R10", r10_viol, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule